// File: doc/BRIEF.md
# Column Driver Pixel Capture and Transfer Front End

This block is the digital input side of a display column driver. On every clock it is offered six gray-level codes of six bits each, which is two colour pixels. A one-hot sampling pointer steps across 80 groups of six columns and stores the six codes in the group it currently marks. The pointer can run from the first group to the last or from the last to the first, and it is armed by a start pulse at the end it begins from. When it leaves the far end it raises a one-cycle cascade pulse on that end, so a neighbouring driver can start its own scan. Until the next start pulse it then stays idle.

A strobe copies all 480 stored codes into an output latch that feeds the later conversion stage. The copy can be bitwise complemented. At the same moment a polarity flag is latched for every column. Neighbouring columns always carry opposite flags, and a polarity input decides which parity is the positive one.

Top module: `column_driver_front`

## Requirements
- R1: After reset every latched code is 0, the pointer is idle, both cascade outputs are low and even-indexed columns (0, 2, ...) are flagged positive.
- R2: With `scan_fwd`=1, a high `start_head_i` arms group 0. On each of the following clocks, the group under the pointer stores `dots_i`, and the pointer then moves to the next higher group. Dot d, taken from bits [6d+5:6d], goes to column 6g+d.
- R3: With `scan_fwd`=0, a high `start_tail_i` arms group 79. Groups are then stored from 79 down to 0, with the same dot-to-column mapping as R2.
- R4: A cascade output goes high for exactly one cycle, the cycle in which the last group of the scan is sampling. In forward scans this is `cascade_tail_o`; in reverse scans it is `cascade_head_o`.
- R5: After the last group the pointer is idle and stored codes no longer change. A start pulse on the end that does not match the direction is ignored.
- R6: A start pulse on the selected end during a scan restarts the scan from that end's first group.
- R7: `code_o` and `pol_pos_o` change only on a clock where `strobe_i` is high. They then show the stored codes as they were before that edge.
- R8: If `invert_i` is high on the strobe clock, each latched code is the bitwise complement of the stored code.
- R9: `pol_i` is sampled on the strobe. Column c is flagged positive when (c is even) XOR `pol_i`, and the flags hold until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_fwd | input | 1 | 1: scan group 0 to 79; 0: scan 79 to 0 |
| start_head_i | input | 1 | Start pulse at the group-0 end (used when scan_fwd=1) |
| start_tail_i | input | 1 | Start pulse at the group-79 end (used when scan_fwd=0) |
| cascade_head_o | output | 1 | Cascade pulse at the group-0 end (reverse scans) |
| cascade_tail_o | output | 1 | Cascade pulse at the group-79 end (forward scans) |
| dots_i | input | 36 | Six 6-bit gray codes; dot d in bits [6d+5:6d] |
| strobe_i | input | 1 | Transfer stored codes to the output latch |
| pol_i | input | 1 | Polarity select sampled on strobe |
| invert_i | input | 1 | Complement codes on transfer |
| code_o | output | 2880 | Latched codes; column c in bits [6c+5:6c] |
| pol_pos_o | output | 480 | Per-column positive-polarity flag |

## Verification
The hardest situations to reach are those where scan and transfer overlap. One is a strobe on the same edge that stores a group, so the latch must take the older contents. Another is a restart or a direction-mismatched start pulse in the middle of a scan. The stimulus drives complete 80-group scans in both directions with position-dependent data patterns. Strobes, restarts and wrong-end pulses are placed at chosen cycles inside those scans. A behavioural model, stepped in lockstep, predicts the latched codes, the flags and the cascade pulses on every clock.

// File: rtl/cdrv_pkg.sv
package cdrv_pkg;
  localparam int unsigned DEF_GROUPS = 80;
  localparam int unsigned DEF_DOTS   = 6;
  localparam int unsigned DEF_BITS   = 6;

  typedef enum logic {
    SCAN_REV = 1'b0,
    SCAN_FWD = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/cdrv_pointer.sv
module cdrv_pointer #(
  parameter int unsigned GROUPS = cdrv_pkg::DEF_GROUPS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_fwd,
  input  logic              start_head,
  input  logic              start_tail,
  output logic [GROUPS-1:0] ptr_o,
  output logic              cas_head_o,
  output logic              cas_tail_o
);
  import cdrv_pkg::*;

  localparam logic [GROUPS-1:0] FIRST_ONE = GROUPS'(1);
  localparam logic [GROUPS-1:0] LAST_ONE  = FIRST_ONE << (GROUPS - 1);

  scan_dir_e         dir;
  logic              start_sel;
  logic [GROUPS-1:0] ptr_q, ptr_d;
  logic              ch_q, ct_q;

  assign dir       = scan_dir_e'(scan_fwd);
  assign start_sel = (dir == SCAN_FWD) ? start_head : start_tail;

  always_comb begin
    if (start_sel) begin
      ptr_d = (dir == SCAN_FWD) ? FIRST_ONE : LAST_ONE;
    end else if (dir == SCAN_FWD) begin
      ptr_d = ptr_q << 1;
    end else begin
      ptr_d = ptr_q >> 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
      ch_q  <= 1'b0;
      ct_q  <= 1'b0;
    end else begin
      ptr_q <= ptr_d;
      ch_q  <= (dir == SCAN_REV) && ptr_d[0];
      ct_q  <= (dir == SCAN_FWD) && ptr_d[GROUPS-1];
    end
  end

  assign ptr_o      = ptr_q;
  assign cas_head_o = ch_q;
  assign cas_tail_o = ct_q;
endmodule

// File: rtl/cdrv_capture.sv
module cdrv_capture #(
  parameter int unsigned GROUPS = cdrv_pkg::DEF_GROUPS,
  parameter int unsigned DOTS   = cdrv_pkg::DEF_DOTS,
  parameter int unsigned BITS   = cdrv_pkg::DEF_BITS
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [GROUPS-1:0]             ptr_i,
  input  logic [DOTS*BITS-1:0]          dots_i,
  output logic [GROUPS*DOTS*BITS-1:0]   store_o
);
  localparam int unsigned ROW_W = DOTS * BITS;

  for (genvar g = 0; g < GROUPS; g++) begin : g_row
    logic [ROW_W-1:0] row_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        row_q <= '0;
      end else if (ptr_i[g]) begin
        row_q <= dots_i;
      end
    end
    assign store_o[g*ROW_W +: ROW_W] = row_q;
  end
endmodule

// File: rtl/cdrv_out_latch.sv
module cdrv_out_latch #(
  parameter int unsigned COLS = 480,
  parameter int unsigned BITS = cdrv_pkg::DEF_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 strobe,
  input  logic                 invert,
  input  logic                 pol,
  input  logic [COLS*BITS-1:0] store_i,
  output logic [COLS*BITS-1:0] code_o,
  output logic [COLS-1:0]      pol_pos_o
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    localparam logic EVEN = ((c % 2) == 0) ? 1'b1 : 1'b0;
    logic [BITS-1:0] code_q;
    logic            pos_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        code_q <= '0;
        pos_q  <= EVEN;
      end else if (strobe) begin
        code_q <= invert ? ~store_i[c*BITS +: BITS] : store_i[c*BITS +: BITS];
        pos_q  <= EVEN ^ pol;
      end
    end
    assign code_o[c*BITS +: BITS] = code_q;
    assign pol_pos_o[c]           = pos_q;
  end
endmodule

// File: rtl/column_driver_front.sv
module column_driver_front #(
  parameter int unsigned GROUPS = cdrv_pkg::DEF_GROUPS,
  parameter int unsigned DOTS   = cdrv_pkg::DEF_DOTS,
  parameter int unsigned BITS   = cdrv_pkg::DEF_BITS,
  localparam int unsigned COLS  = GROUPS * DOTS,
  localparam int unsigned ROW_W = DOTS * BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scan_fwd,
  input  logic                 start_head_i,
  input  logic                 start_tail_i,
  output logic                 cascade_head_o,
  output logic                 cascade_tail_o,
  input  logic [ROW_W-1:0]     dots_i,
  input  logic                 strobe_i,
  input  logic                 pol_i,
  input  logic                 invert_i,
  output logic [COLS*BITS-1:0] code_o,
  output logic [COLS-1:0]      pol_pos_o
);
  logic [GROUPS-1:0]    ptr_w;
  logic [COLS*BITS-1:0] store_w;

  cdrv_pointer #(.GROUPS(GROUPS)) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .scan_fwd   (scan_fwd),
    .start_head (start_head_i),
    .start_tail (start_tail_i),
    .ptr_o      (ptr_w),
    .cas_head_o (cascade_head_o),
    .cas_tail_o (cascade_tail_o)
  );

  cdrv_capture #(.GROUPS(GROUPS), .DOTS(DOTS), .BITS(BITS)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .ptr_i   (ptr_w),
    .dots_i  (dots_i),
    .store_o (store_w)
  );

  cdrv_out_latch #(.COLS(COLS), .BITS(BITS)) u_lat (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe_i),
    .invert    (invert_i),
    .pol       (pol_i),
    .store_i   (store_w),
    .code_o    (code_o),
    .pol_pos_o (pol_pos_o)
  );
endmodule

// File: rtl/cdrv_checker.sv
module cdrv_checker #(
  parameter int unsigned GROUPS = cdrv_pkg::DEF_GROUPS,
  parameter int unsigned COLS   = 480,
  parameter int unsigned BITS   = cdrv_pkg::DEF_BITS
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 scan_fwd,
  input logic                 start_head_i,
  input logic                 start_tail_i,
  input logic                 strobe_i,
  input logic                 pol_i,
  input logic [GROUPS-1:0]    ptr,
  input logic                 cascade_head_o,
  input logic                 cascade_tail_o,
  input logic [COLS*BITS-1:0] code_o,
  input logic [COLS-1:0]      pol_pos_o
);
  logic sel_start;
  assign sel_start = scan_fwd ? start_head_i : start_tail_i;

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (ptr == '0 && !cascade_head_o && !cascade_tail_o));

  assert_fwd_step_R2: assert property (@(posedge clk) disable iff (rst)
    (scan_fwd && !start_head_i && ptr != '0 && !ptr[GROUPS-1])
      |=> ptr == ($past(ptr) << 1));

  assert_rev_step_R3: assert property (@(posedge clk) disable iff (rst)
    (!scan_fwd && !start_tail_i && ptr != '0 && !ptr[0])
      |=> ptr == ($past(ptr) >> 1));

  assert_cas_tail_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    cascade_tail_o |=> !cascade_tail_o);

  assert_cas_head_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    cascade_head_o |=> !cascade_head_o);

  assert_ptr_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ptr));

  assert_idle_stays_R5: assert property (@(posedge clk) disable iff (rst)
    (ptr == '0 && !sel_start) |=> ptr == '0);

  assert_restart_head_R6: assert property (@(posedge clk) disable iff (rst)
    (scan_fwd && start_head_i) |=> (ptr[0] && $countones(ptr) == 1));

  assert_hold_no_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    !strobe_i |=> ($stable(code_o) && $stable(pol_pos_o)));

  assert_pol_sample_R9: assert property (@(posedge clk) disable iff (rst)
    strobe_i |=> (pol_pos_o[0] == !$past(pol_i) && pol_pos_o[1] == $past(pol_i)));
endmodule

bind column_driver_front cdrv_checker #(
  .GROUPS(GROUPS), .COLS(COLS), .BITS(BITS)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .scan_fwd       (scan_fwd),
  .start_head_i   (start_head_i),
  .start_tail_i   (start_tail_i),
  .strobe_i       (strobe_i),
  .pol_i          (pol_i),
  .ptr            (ptr_w),
  .cascade_head_o (cascade_head_o),
  .cascade_tail_o (cascade_tail_o),
  .code_o         (code_o),
  .pol_pos_o      (pol_pos_o)
);

// File: tb/sim_column_driver_front.sv
module sim_column_driver_front;
  localparam int G = 80;
  localparam int D = 6;
  localparam int B = 6;
  localparam int C = G * D;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scan_fwd = 1'b1;
  logic start_head_i = 1'b0;
  logic start_tail_i = 1'b0;
  logic cascade_head_o, cascade_tail_o;
  logic [D*B-1:0] dots_i = '0;
  logic strobe_i = 1'b0;
  logic pol_i = 1'b0;
  logic invert_i = 1'b0;
  logic [C*B-1:0] code_o;
  logic [C-1:0] pol_pos_o;

  column_driver_front u0 (
    .clk(clk), .rst(rst), .scan_fwd(scan_fwd),
    .start_head_i(start_head_i), .start_tail_i(start_tail_i),
    .cascade_head_o(cascade_head_o), .cascade_tail_o(cascade_tail_o),
    .dots_i(dots_i), .strobe_i(strobe_i), .pol_i(pol_i), .invert_i(invert_i),
    .code_o(code_o), .pol_pos_o(pol_pos_o)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  int ref_reg [C];
  int ref_lat [C];
  bit ref_pos [C];
  int ref_ptr = -1;
  bit ref_ch = 0;
  bit ref_ct = 0;

  function automatic logic [D*B-1:0] pat(int k, int seed);
    logic [D*B-1:0] r;
    for (int d = 0; d < D; d++) r[d*B +: B] = B'(k * 5 + d * 11 + seed);
    return r;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < C; c++) begin
      ref_reg[c] = 0; ref_lat[c] = 0; ref_pos[c] = ((c % 2) == 0);
    end
    ref_ptr = -1; ref_ch = 0; ref_ct = 0;
  endtask

  task automatic model_edge();
    bit st;
    if (strobe_i) begin
      for (int c = 0; c < C; c++) begin
        ref_lat[c] = invert_i ? (~ref_reg[c] & 63) : ref_reg[c];
        ref_pos[c] = ((c % 2) == 0) ^ pol_i;
      end
    end
    if (ref_ptr >= 0)
      for (int d = 0; d < D; d++) ref_reg[ref_ptr * D + d] = int'(dots_i[d*B +: B]);
    st = scan_fwd ? start_head_i : start_tail_i;
    if (st) ref_ptr = scan_fwd ? 0 : G - 1;
    else if (ref_ptr >= 0) begin
      if (scan_fwd) ref_ptr = (ref_ptr == G - 1) ? -1 : ref_ptr + 1;
      else ref_ptr = ref_ptr - 1;
    end
    ref_ch = !scan_fwd && ref_ptr == 0;
    ref_ct = scan_fwd && ref_ptr == G - 1;
  endtask

  task automatic compare();
    int bad;
    bad = -1;
    checks++;
    for (int c = 0; c < C; c++)
      if (bad < 0 && int'(code_o[c*B +: B]) != ref_lat[c]) bad = c;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s code col %0d actual %0d expected %0d", tag, bad,
               code_o[bad*B +: B], ref_lat[bad]);
    end
    bad = -1;
    checks++;
    for (int c = 0; c < C; c++)
      if (bad < 0 && pol_pos_o[c] != ref_pos[c]) bad = c;
    if (bad >= 0) begin
      errors++;
      $display("FAIL R9 polarity col %0d actual %0b expected %0b", bad,
               pol_pos_o[bad], ref_pos[bad]);
    end
    checks++;
    if (cascade_head_o != ref_ch || cascade_tail_o != ref_ct) begin
      errors++;
      $display("FAIL R4 cascade head/tail actual %0b%0b expected %0b%0b",
               cascade_head_o, cascade_tail_o, ref_ch, ref_ct);
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic [D*B-1:0] d, input logic hs, input logic ts,
                      input logic fwd, input logic stb, input logic pl, input logic inv);
    dots_i = d; start_head_i = hs; start_tail_i = ts; scan_fwd = fwd;
    strobe_i = stb; pol_i = pl; invert_i = inv;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic scan(input logic fwd, input int seed, input int n);
    for (int k = 0; k < n; k++) step(pat(k, seed), 0, 0, fwd, 0, 0, 0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R1";
    compare();
    step('0, 0, 0, 1, 0, 0, 0);

    // R2 forward scan, then transfer
    tag = "R2";
    step(pat(0, 99), 1, 0, 1, 0, 0, 0);
    scan(1, 3, G);
    step('0, 0, 0, 1, 1, 0, 0);

    // R5 data after end and wrong-end start are ignored
    tag = "R5";
    scan(1, 40, 4);
    step(pat(1, 17), 0, 1, 1, 0, 0, 0);
    scan(1, 41, 6);
    step('0, 0, 0, 1, 1, 0, 0);

    // R3 reverse scan, R8 inversion with R9 polarity swap
    tag = "R3 R8";
    step('0, 0, 1, 0, 0, 0, 0);
    scan(0, 7, G);
    step('0, 0, 0, 0, 1, 1, 1);
    step('0, 0, 0, 0, 0, 0, 0);

    // R6 restart mid-scan
    tag = "R6";
    step('0, 1, 0, 1, 0, 0, 0);
    scan(1, 21, 25);
    step(pat(2, 5), 1, 0, 1, 0, 0, 0);
    scan(1, 33, G);
    step('0, 0, 0, 1, 1, 0, 0);

    // R7 strobe on a capture edge takes older contents
    tag = "R7";
    step('0, 1, 0, 1, 0, 0, 0);
    scan(1, 50, 5);
    step(pat(5, 60), 0, 0, 1, 1, 1, 0);
    scan(1, 51, 10);
    step('0, 0, 0, 1, 1, 0, 1);
    scan(1, 52, G);
    step('0, 0, 0, 1, 1, 1, 0);
    step('0, 0, 0, 1, 0, 0, 0);

    finish_run();
  end
endmodule